// File: doc/BRIEF.md
# Dual-Clock Serial Result Readout

This block is the serial output stage of a successive-approximation converter. It puts the 14-bit result on one data pin, most significant bit first, in one of two ways. While a conversion is running, each bit is shown as soon as the conversion controller decides it, so a host can read the result at the conversion-clock rate. After the conversion, the completed word is kept and can be shifted out at any later time on a separate serial clock. That serial clock runs without any fixed relation to the conversion clock.

An active-low chip select enables the whole interface. The three-state pin is modelled here as a data bit plus an output-enable. The completed word is captured in the conversion-clock domain. It is then handed to the serial-clock domain with a toggle request and a toggle acknowledge, each passing through a synchroniser chain. A new word never replaces the one being read while chip select is low. It waits until the host deselects the block.

Top module: `dual_clock_result_serializer`

## Requirements
- R1: After reset, with chip select low, no conversion running and no word yet delivered, `dout` is 0 and `dout_oe` is 1.
- R2: `dout_oe` is 1 exactly when `cs_n` is 0.
- R3: While a conversion is in progress, `dout` shows the bit from the most recent cycle in which `bit_valid` was 1. The change appears one `clk` rising edge after that cycle. Between such cycles the bit is held. `conv_active` selects this live mode one `clk` edge later.
- R4: A pulse on `conv_done` captures `conv_word`, with bit 13 as the MSB. The word becomes the serial-clock word on the first falling `sclk` edge at which both of these are true: chip select is high, and at least SYNC_STAGES+1 falling edges have occurred since the capture. A new `conv_done` must not arrive while the previous handoff is still unacknowledged.
- R5: In serial-clock mode the MSB is shown as soon as `cs_n` falls. Each falling `sclk` edge with chip select low moves the output one bit toward the LSB.
- R6: After WORD_W falling edges in one selection, `dout` is 0 until chip select is raised and lowered again.
- R7: Raising `cs_n` in the middle of a word abandons the shift. The next selection starts again at the MSB of the latest delivered word.
- R8: A word that finishes its handoff while chip select is low does not disturb the word being read. It is taken over at the first falling `sclk` edge that sees chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset, held over edges of both clocks |
| conv_active | input | 1 | Conversion in progress (selects live mode) |
| bit_valid | input | 1 | A result bit was decided this cycle |
| bit_val | input | 1 | Value of the decided bit |
| conv_done | input | 1 | One-cycle pulse: `conv_word` holds the completed result |
| conv_word | input | WORD_W | Completed result, bit WORD_W-1 is the MSB |
| sclk | input | 1 | Serial clock, asynchronous to `clk`; data changes on its falling edge |
| cs_n | input | 1 | Active-low chip select |
| dout | output | 1 | Serial data |
| dout_oe | output | 1 | Output enable of the data pin |

## Verification
The bench builds the block with a 14-bit word and a two-flop synchroniser. With these values, a full read plus overrun into the zero tail takes about twenty serial edges. The handoff becomes visible after three edges, which lets a bench edge count check the deferred take-over exactly. The serial clock is driven a few nanoseconds after chosen conversion-clock edges, spanning several of them per period. This exercises live streaming with irregular gaps, reads that are cut off part-way, and a word that arrives while chip select is low.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int unsigned RSR_WORD_W_DEF = 14;
  localparam int unsigned RSR_SYNC_DEF   = 2;

  function automatic int unsigned rsr_cnt_bits(input int unsigned w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/rsr_sync_chain.sv
module rsr_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/rsr_live_tap.sv
module rsr_live_tap (
  input  logic clk,
  input  logic rst,
  input  logic conv_active,
  input  logic bit_valid,
  input  logic bit_val,
  output logic live_mode,
  output logic live_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      live_mode <= 1'b0;
      live_bit  <= 1'b0;
    end else begin
      live_mode <= conv_active;
      if (bit_valid) live_bit <= bit_val;
    end
  end

  // R3: a decided bit is visible one edge later
  assert_live_bit_R3: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> (live_bit == $past(bit_val)));
endmodule

// File: rtl/rsr_word_handoff.sv
module rsr_word_handoff #(
  parameter int unsigned WORD_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] conv_word,
  input  logic              ack_tgl,
  output logic [WORD_W-1:0] hold_word,
  output logic              req_tgl
);
  logic ack_seen;
  logic busy;

  rsr_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_seen)
  );

  assign busy = req_tgl ^ ack_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word <= '0;
      req_tgl   <= 1'b0;
    end else if (conv_done) begin
      hold_word <= conv_word;
      req_tgl   <= ~req_tgl;
    end
  end

  // R4: no new result while the previous handoff is still open
  assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> !busy);

  // R4: held word only moves after a completion pulse
  assert_hold_capture_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(hold_word) |-> $past(conv_done));
endmodule

// File: rtl/rsr_sclk_shifter.sv
module rsr_sclk_shifter
  import rsr_pkg::*;
#(
  parameter int unsigned WORD_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [WORD_W-1:0] hold_word,
  input  logic              req_tgl,
  output logic              ack_tgl,
  output logic              ser_bit
);
  localparam int unsigned CNT_W = rsr_cnt_bits(WORD_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WORD_W);

  logic              sclk_fall;
  logic              req_seen;
  logic [WORD_W-1:0] shadow;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shifted;
  logic              pending;

  assign sclk_fall = ~sclk;

  rsr_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(sclk_fall), .rst(rst), .d(req_tgl), .q(req_seen)
  );

  assign pending = req_seen ^ ack_tgl;

  always_ff @(posedge sclk_fall) begin
    if (rst) begin
      shadow  <= '0;
      ack_tgl <= 1'b0;
    end else if (pending && cs_n) begin
      shadow  <= hold_word;
      ack_tgl <= req_seen;
    end
  end

  always_ff @(posedge sclk_fall or posedge cs_n) begin
    if (cs_n)               cnt <= '0;
    else if (rst)           cnt <= '0;
    else if (cnt != CNT_END) cnt <= cnt + 1'b1;
  end

  assign shifted = shadow << cnt;
  assign ser_bit = (cnt < CNT_END) ? shifted[WORD_W-1] : 1'b0;

  // R8: a pending word is not taken while the host is reading
  assert_defer_load_R8: assert property (@(posedge sclk_fall) disable iff (rst)
    (pending && !cs_n) |=> (shadow == $past(shadow)));
endmodule

// File: rtl/dual_clock_result_serializer.sv
module dual_clock_result_serializer
  import rsr_pkg::*;
#(
  parameter int unsigned WORD_W      = RSR_WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = RSR_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_active,
  input  logic              bit_valid,
  input  logic              bit_val,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] conv_word,
  input  logic              sclk,
  input  logic              cs_n,
  output logic              dout,
  output logic              dout_oe
);
  logic              live_mode;
  logic              live_bit;
  logic [WORD_W-1:0] hold_word;
  logic              req_tgl;
  logic              ack_tgl;
  logic              ser_bit;

  rsr_live_tap u_live (
    .clk(clk), .rst(rst), .conv_active(conv_active),
    .bit_valid(bit_valid), .bit_val(bit_val),
    .live_mode(live_mode), .live_bit(live_bit)
  );

  rsr_word_handoff #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_handoff (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_word(conv_word),
    .ack_tgl(ack_tgl), .hold_word(hold_word), .req_tgl(req_tgl)
  );

  rsr_sclk_shifter #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .sclk(sclk), .rst(rst), .cs_n(cs_n), .hold_word(hold_word),
    .req_tgl(req_tgl), .ack_tgl(ack_tgl), .ser_bit(ser_bit)
  );

  assign dout    = live_mode ? live_bit : ser_bit;
  assign dout_oe = ~cs_n;
endmodule

// File: tb/dual_clock_result_serializer_tb_top.sv
module dual_clock_result_serializer_tb_top;
  localparam int W  = 14;
  localparam int SS = 2;

  logic clk = 0, rst = 1, sclk = 0, cs_n = 1;
  logic conv_active = 0, bit_valid = 0, bit_val = 0, conv_done = 0;
  logic [W-1:0] conv_word = '0;
  wire dout, dout_oe;

  dual_clock_result_serializer #(.WORD_W(W), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst(rst), .conv_active(conv_active), .bit_valid(bit_valid),
    .bit_val(bit_val), .conv_done(conv_done), .conv_word(conv_word),
    .sclk(sclk), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  bit m_live_mode = 0, m_live_bit = 0, m_pend = 0;
  logic [W-1:0] m_shadow = '0, m_hold = '0;
  int m_idx = 0, m_since = 0;
  string phase = "R1";
  bit checking = 0, finished = 0;
  int n_checks = 0, n_fail = 0;

  always @(negedge clk) if (checking) begin
    logic expv;
    n_checks++;
    if (dout_oe !== !cs_n) begin
      n_fail++;
      $display("FAIL R2: dout_oe=%0b expected %0b", dout_oe, !cs_n);
    end
    if (!cs_n) begin
      if (m_live_mode) expv = m_live_bit;
      else if (m_idx < W) expv = m_shadow[W-1-m_idx];
      else expv = 1'b0;
      n_checks++;
      if (dout !== expv) begin
        n_fail++;
        $display("FAIL %s: dout=%0b expected %0b (t=%0t)", phase, dout, expv, $time);
      end
    end
  end

  task automatic sclk_pulse();
    @(posedge clk); #2 sclk = 1;
    @(posedge clk); #2 sclk = 0;
    if (!rst) begin
      if (!cs_n && m_idx < W) m_idx++;
      if (m_pend) begin
        m_since++;
        if (m_since >= SS + 1 && cs_n) begin
          m_shadow = m_hold;
          m_pend = 0;
        end
      end
    end
  endtask

  task automatic set_cs(input logic v);
    @(posedge clk); #2 cs_n = v;
    if (v) m_idx = 0;
  endtask

  task automatic conv_start();
    @(posedge clk); #2 conv_active = 1;
    @(posedge clk); #1 m_live_mode = 1;
  endtask

  task automatic live_bit(input logic b, input int gap);
    @(posedge clk); #2 bit_valid = 1; bit_val = b;
    @(posedge clk); #1 m_live_bit = b;
    #1 bit_valid = 0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic conv_finish(input logic [W-1:0] w);
    @(posedge clk); #2 conv_done = 1; conv_word = w; conv_active = 0;
    @(posedge clk); #1 m_live_mode = 0; m_hold = w; m_pend = 1; m_since = 0;
    #1 conv_done = 0;
  endtask

  task automatic convert(input logic [W-1:0] w);
    conv_start();
    for (int i = W - 1; i >= 0; i--) live_bit(w[i], i % 3);
    conv_finish(w);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    repeat (3) sclk_pulse();
    @(posedge clk); #2 rst = 0;
    checking = 1;

    phase = "R1"; set_cs(0); repeat (3) @(posedge clk);

    phase = "R3"; convert(14'h2A5C);

    phase = "R8"; repeat (5) sclk_pulse();

    phase = "R4"; set_cs(1); sclk_pulse(); repeat (4) @(posedge clk);
    set_cs(0); repeat (2) @(posedge clk);

    phase = "R5"; repeat (W) sclk_pulse();
    phase = "R6"; repeat (3) sclk_pulse();

    phase = "R7"; set_cs(1); set_cs(0); repeat (5) sclk_pulse();
    set_cs(1); set_cs(0); repeat (2) @(posedge clk); repeat (2) sclk_pulse();

    phase = "R3"; set_cs(1); convert(14'h3003);
    phase = "R4"; repeat (SS + 1) sclk_pulse(); repeat (4) @(posedge clk);
    set_cs(0);
    phase = "R5"; repeat (W) sclk_pulse();
    phase = "R6"; repeat (2) sclk_pulse();
    set_cs(1); repeat (2) @(posedge clk);

    checking = 0;
    finished = 1;
    summary();
    $finish;
  end
endmodule